// File: doc/BRIEF.md
# Tag-Directed Crypto Stream Router

The router sits between a fetch DMA and three crypto engine ports: AES, hash and a bypass path. Words arrive as blocks. Each word carries a 16-bit tag and an end-of-block marker. The router reads the tag of the first word of a block, holds it, and applies that decision to every word of the block. The tag on later words of the block has no effect.

The tag decides four things:
- which engine receives the block;
- whether the words become configuration-register writes or a data stream;
- which datatype the engine sees;
- whether the last side-band signal is raised on the final word.

Configuration blocks are turned into a run of register writes. The first write goes to the start offset held in the tag, and the offset then rises by four for each word. Blocks with an unknown engine code are consumed and discarded, and a sticky error flag is raised.

The input is a valid/ready stream. For a data block, `s_ready` is taken straight from the `*_dat_ready` of the selected data port. A word moves only on a cycle where valid and ready are both high. While the port stalls, the word, its tag and `s_eob` must stay stable. Configuration writes and dropped words are always accepted. The path from input to output is purely combinational, with no buffering stage.

Top module: `crypto_tag_router`

## Requirements
- R1: Tag bits [3:0] pick the target: 4'h1 is AES, 4'h3 is hash, 4'hF is bypass. An accepted word appears on at most one of the six output strobes (three `*_cfg_we`, three `*_dat_valid`).
- R2: When tag bit 4 is 1, each word is presented as a configuration write: `*_cfg_we` is high and `*_cfg_data` equals `s_data`. The target's `*_dat_valid` stays low.
- R3: The configuration offset of word k (counting from 0) in a block is tag[15:8] + 4·k, modulo 256.
- R4: When tag bit 4 is 0, each word goes to the data port: `*_dat_valid` is high, `*_dat_data` equals `s_data`, and `*_dat_type` equals tag[7:6].
- R5: `*_dat_last` is high only on the word with `s_eob`=1, and only when tag bit 5 of the block is 1.
- R6: Only the tag of a block's first word is used. `s_tag` on later words of the block has no effect on any output.
- R7: For a data block, `s_ready` equals the selected port's `*_dat_ready`. For configuration blocks and dropped blocks, `s_ready` is 1. While the port stalls, the word stays presented.
- R8: A block with any other engine code is accepted and produces no strobe on any port. From the cycle after its first word is accepted, `drop_err` is 1 and stays 1 until reset.
- R9: After reset, `drop_err` is 0 and no strobe is raised while `s_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word accepted |
| s_data | input | DATA_W | Input word |
| s_tag | input | 16 | Block tag (used on the first word only) |
| s_eob | input | 1 | Final word of block |
| aes_cfg_off | output | 8 | AES config register byte offset |
| aes_cfg_data | output | DATA_W | AES config write data |
| aes_cfg_we | output | 1 | AES config write strobe |
| aes_dat_data | output | DATA_W | AES stream data |
| aes_dat_type | output | 2 | AES datatype |
| aes_dat_last | output | 1 | AES last side-band |
| aes_dat_valid | output | 1 | AES stream valid |
| aes_dat_ready | input | 1 | AES stream ready |
| hash_cfg_off | output | 8 | Hash config register byte offset |
| hash_cfg_data | output | DATA_W | Hash config write data |
| hash_cfg_we | output | 1 | Hash config write strobe |
| hash_dat_data | output | DATA_W | Hash stream data |
| hash_dat_type | output | 2 | Hash datatype |
| hash_dat_last | output | 1 | Hash last side-band |
| hash_dat_valid | output | 1 | Hash stream valid |
| hash_dat_ready | input | 1 | Hash stream ready |
| byp_cfg_off | output | 8 | Bypass config register byte offset |
| byp_cfg_data | output | DATA_W | Bypass config write data |
| byp_cfg_we | output | 1 | Bypass config write strobe |
| byp_dat_data | output | DATA_W | Bypass stream data |
| byp_dat_type | output | 2 | Bypass datatype |
| byp_dat_last | output | 1 | Bypass last side-band |
| byp_dat_valid | output | 1 | Bypass stream valid |
| byp_dat_ready | input | 1 | Bypass stream ready |
| drop_err | output | 1 | Sticky unknown-engine flag |

## Verification
The router keeps only three pieces of state: the held tag, the in-block flag and the word index. A fault in any of them shows up on the very next word of a block.
- A stale held tag sends later words to the wrong port or with the wrong datatype.
- A wrong index shifts configuration offsets away from base + 4·k.
- An in-block flag that fails to clear makes the next block follow the previous block's tag.

Every engine code, routing choice, last bit and block length from one to three words is swept. Later words carry a deliberately wrong tag, so any of these faults is caught at the word where it first occurs.

// File: rtl/tr_pkg.sv
package tr_pkg;
  localparam int TAG_W   = 16;
  localparam int OFF_W   = 8;
  localparam int TYPE_W  = 2;
  localparam int N_PORTS = 3;

  localparam logic [3:0] CODE_AES  = 4'h1;
  localparam logic [3:0] CODE_HASH = 4'h3;
  localparam logic [3:0] CODE_BYP  = 4'hF;

  typedef enum logic [1:0] {
    TGT_AES  = 2'd0,
    TGT_HASH = 2'd1,
    TGT_BYP  = 2'd2,
    TGT_NONE = 2'd3
  } tgt_e;

  typedef struct packed {
    tgt_e              tgt;
    logic              to_cfg;
    logic              last_req;
    logic [TYPE_W-1:0] dtype;
    logic [OFF_W-1:0]  base;
  } route_t;
endpackage

// File: rtl/tr_tag_decode.sv
module tr_tag_decode
  import tr_pkg::*;
(
  input  logic [TAG_W-1:0] tag,
  output route_t           route
);
  always_comb begin
    unique case (tag[3:0])
      CODE_AES:  route.tgt = TGT_AES;
      CODE_HASH: route.tgt = TGT_HASH;
      CODE_BYP:  route.tgt = TGT_BYP;
      default:   route.tgt = TGT_NONE;
    endcase
    route.to_cfg   = tag[4];
    route.last_req = tag[5];
    route.dtype    = tag[7:6];
    route.base     = tag[15:8];
  end
endmodule

// File: rtl/tr_block_track.sv
module tr_block_track
  import tr_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             eob,
  input  logic [TAG_W-1:0] in_tag,
  output logic [TAG_W-1:0] cur_tag,
  output logic [IDX_W-1:0] idx
);
  logic             mid_q;
  logic [TAG_W-1:0] tag_q;

  assign cur_tag = mid_q ? tag_q : in_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q <= 1'b0;
      tag_q <= '0;
      idx   <= '0;
    end else if (fire) begin
      if (eob) begin
        mid_q <= 1'b0;
        idx   <= '0;
      end else begin
        mid_q <= 1'b1;
        idx   <= idx + 1'b1;
        if (!mid_q) tag_q <= in_tag;
      end
    end
  end
endmodule

// File: rtl/tr_port_steer.sv
module tr_port_steer
  import tr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic                      s_valid,
  input  logic                      s_eob,
  input  route_t                    route,
  input  logic [IDX_W-1:0]          idx,
  input  logic [N_PORTS-1:0]        dat_ready,
  output logic                      s_ready,
  output logic [N_PORTS-1:0]        cfg_we,
  output logic [N_PORTS-1:0]        dat_valid,
  output logic [N_PORTS-1:0]        dat_last,
  output logic [OFF_W-1:0]          cfg_off
);
  localparam int SUM_W = (IDX_W + 2 > OFF_W) ? IDX_W + 2 : OFF_W;

  logic [SUM_W-1:0] off_sum;
  assign off_sum = SUM_W'(route.base) + (SUM_W'(idx) << 2);
  assign cfg_off = off_sum[OFF_W-1:0];

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    logic sel;
    assign sel          = (route.tgt == tgt_e'(p));
    assign cfg_we[p]    = s_valid & sel & route.to_cfg;
    assign dat_valid[p] = s_valid & sel & ~route.to_cfg;
    assign dat_last[p]  = route.last_req & s_eob;
  end

  always_comb begin
    if (route.to_cfg) s_ready = 1'b1;
    else begin
      unique case (route.tgt)
        TGT_AES:  s_ready = dat_ready[0];
        TGT_HASH: s_ready = dat_ready[1];
        TGT_BYP:  s_ready = dat_ready[2];
        default:  s_ready = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/crypto_tag_router.sv
module crypto_tag_router
  import tr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic [15:0]       s_tag,
  input  logic              s_eob,
  output logic [7:0]        aes_cfg_off,
  output logic [DATA_W-1:0] aes_cfg_data,
  output logic              aes_cfg_we,
  output logic [DATA_W-1:0] aes_dat_data,
  output logic [1:0]        aes_dat_type,
  output logic              aes_dat_last,
  output logic              aes_dat_valid,
  input  logic              aes_dat_ready,
  output logic [7:0]        hash_cfg_off,
  output logic [DATA_W-1:0] hash_cfg_data,
  output logic              hash_cfg_we,
  output logic [DATA_W-1:0] hash_dat_data,
  output logic [1:0]        hash_dat_type,
  output logic              hash_dat_last,
  output logic              hash_dat_valid,
  input  logic              hash_dat_ready,
  output logic [7:0]        byp_cfg_off,
  output logic [DATA_W-1:0] byp_cfg_data,
  output logic              byp_cfg_we,
  output logic [DATA_W-1:0] byp_dat_data,
  output logic [1:0]        byp_dat_type,
  output logic              byp_dat_last,
  output logic              byp_dat_valid,
  input  logic              byp_dat_ready,
  output logic              drop_err
);
  logic [TAG_W-1:0]   cur_tag;
  logic [IDX_W-1:0]   idx;
  route_t             route;
  logic [N_PORTS-1:0] cfg_we, dat_valid, dat_last;
  logic [OFF_W-1:0]   cfg_off;
  logic               fire;

  assign fire = s_valid & s_ready;

  tr_block_track #(.IDX_W(IDX_W)) u_track (
    .clk(clk), .rst_n(rst_n), .fire(fire), .eob(s_eob),
    .in_tag(s_tag), .cur_tag(cur_tag), .idx(idx)
  );

  tr_tag_decode u_dec (.tag(cur_tag), .route(route));

  tr_port_steer #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_steer (
    .s_valid(s_valid), .s_eob(s_eob), .route(route), .idx(idx),
    .dat_ready({byp_dat_ready, hash_dat_ready, aes_dat_ready}),
    .s_ready(s_ready), .cfg_we(cfg_we), .dat_valid(dat_valid),
    .dat_last(dat_last), .cfg_off(cfg_off)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_err <= 1'b0;
    else if (fire && route.tgt == TGT_NONE) drop_err <= 1'b1;
  end

  assign aes_cfg_off    = cfg_off;
  assign aes_cfg_data   = s_data;
  assign aes_cfg_we     = cfg_we[0];
  assign aes_dat_data   = s_data;
  assign aes_dat_type   = route.dtype;
  assign aes_dat_last   = dat_last[0];
  assign aes_dat_valid  = dat_valid[0];

  assign hash_cfg_off   = cfg_off;
  assign hash_cfg_data  = s_data;
  assign hash_cfg_we    = cfg_we[1];
  assign hash_dat_data  = s_data;
  assign hash_dat_type  = route.dtype;
  assign hash_dat_last  = dat_last[1];
  assign hash_dat_valid = dat_valid[1];

  assign byp_cfg_off    = cfg_off;
  assign byp_cfg_data   = s_data;
  assign byp_cfg_we     = cfg_we[2];
  assign byp_dat_data   = s_data;
  assign byp_dat_type   = route.dtype;
  assign byp_dat_last   = dat_last[2];
  assign byp_dat_valid  = dat_valid[2];
endmodule

// File: rtl/tr_router_chk.sv
module tr_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s_valid,
  input logic       s_ready,
  input logic       s_eob,
  input logic       aes_cfg_we,
  input logic [7:0] aes_cfg_off,
  input logic       hash_cfg_we,
  input logic       byp_cfg_we,
  input logic       aes_dat_valid,
  input logic       aes_dat_ready,
  input logic       aes_dat_last,
  input logic       hash_dat_valid,
  input logic       hash_dat_ready,
  input logic       byp_dat_valid,
  input logic       byp_dat_ready,
  input logic       drop_err
);
  // R1
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({aes_cfg_we, hash_cfg_we, byp_cfg_we,
              aes_dat_valid, hash_dat_valid, byp_dat_valid}));

  // R2
  cfg_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aes_cfg_we || hash_cfg_we || byp_cfg_we) |-> s_ready);

  // R3
  cfg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aes_cfg_we && $past(aes_cfg_we && !s_eob)) |-> aes_cfg_off == $past(aes_cfg_off) + 8'd4);

  // R5
  last_eob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aes_dat_valid && aes_dat_last) |-> s_eob);

  // R7
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |-> ((aes_dat_valid && !aes_dat_ready) ||
                               (hash_dat_valid && !hash_dat_ready) ||
                               (byp_dat_valid && !byp_dat_ready)));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_err |=> drop_err);
endmodule

bind crypto_tag_router tr_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_eob(s_eob),
  .aes_cfg_we(aes_cfg_we), .aes_cfg_off(aes_cfg_off), .hash_cfg_we(hash_cfg_we),
  .byp_cfg_we(byp_cfg_we), .aes_dat_valid(aes_dat_valid), .aes_dat_ready(aes_dat_ready),
  .aes_dat_last(aes_dat_last), .hash_dat_valid(hash_dat_valid),
  .hash_dat_ready(hash_dat_ready), .byp_dat_valid(byp_dat_valid),
  .byp_dat_ready(byp_dat_ready), .drop_err(drop_err)
);

// File: tb/test_crypto_tag_router.sv
module test_crypto_tag_router;
  localparam int DW = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic s_valid = 0, s_ready, s_eob = 0;
  logic [DW-1:0] s_data = '0;
  logic [15:0] s_tag = '0;
  logic [7:0] a_off, h_off, b_off;
  logic [DW-1:0] a_cd, h_cd, b_cd, a_dd, h_dd, b_dd;
  logic a_we, h_we, b_we, a_dv, h_dv, b_dv, a_dl, h_dl, b_dl;
  logic [1:0] a_dt, h_dt, b_dt;
  logic a_rdy = 1, h_rdy = 1, b_rdy = 1;
  logic drop_err;

  crypto_tag_router #(.DATA_W(DW), .IDX_W(6)) i_crypto_tag_router (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_tag(s_tag), .s_eob(s_eob),
    .aes_cfg_off(a_off), .aes_cfg_data(a_cd), .aes_cfg_we(a_we),
    .aes_dat_data(a_dd), .aes_dat_type(a_dt), .aes_dat_last(a_dl),
    .aes_dat_valid(a_dv), .aes_dat_ready(a_rdy),
    .hash_cfg_off(h_off), .hash_cfg_data(h_cd), .hash_cfg_we(h_we),
    .hash_dat_data(h_dd), .hash_dat_type(h_dt), .hash_dat_last(h_dl),
    .hash_dat_valid(h_dv), .hash_dat_ready(h_rdy),
    .byp_cfg_off(b_off), .byp_cfg_data(b_cd), .byp_cfg_we(b_we),
    .byp_dat_data(b_dd), .byp_dat_type(b_dt), .byp_dat_last(b_dl),
    .byp_dat_valid(b_dv), .byp_dat_ready(b_rdy),
    .drop_err(drop_err)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  bit exp_err = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int port_of(input logic [3:0] code);
    if (code == 4'h1) return 0;
    if (code == 4'h3) return 1;
    if (code == 4'hF) return 2;
    return 3;
  endfunction

  // Sample combinational outputs of the presented word (called 1 ns after a negedge)
  task automatic check_word(input logic [15:0] tag, input int k, input bit eob, input bit exp_rdy);
    int p;
    logic [5:0] obs, exp_s;
    logic [7:0] off;
    logic [7:0] obs_off;
    logic [DW-1:0] obs_d;
    logic [1:0] obs_t;
    logic obs_l;
    p = port_of(tag[3:0]);
    obs = {b_dv, h_dv, a_dv, b_we, h_we, a_we};
    exp_s = '0;
    if (p < 3) begin
      if (tag[4]) exp_s[p] = 1'b1; else exp_s[p+3] = 1'b1;
    end
    // R1 R2 R8: exactly the expected strobe, none for unknown codes
    chk(obs == exp_s, p == 3 ? "R8" : (tag[4] ? "R2" : "R1"), 32'(obs), 32'(exp_s));
    // R7
    chk(s_ready == exp_rdy, "R7", 32'(s_ready), 32'(exp_rdy));
    if (p < 3) begin
      obs_off = (p == 0) ? a_off : (p == 1) ? h_off : b_off;
      obs_d   = tag[4] ? ((p == 0) ? a_cd : (p == 1) ? h_cd : b_cd)
                       : ((p == 0) ? a_dd : (p == 1) ? h_dd : b_dd);
      obs_t   = (p == 0) ? a_dt : (p == 1) ? h_dt : b_dt;
      obs_l   = (p == 0) ? a_dl : (p == 1) ? h_dl : b_dl;
      chk(obs_d == s_data, tag[4] ? "R2" : "R4", obs_d, s_data);
      if (tag[4]) begin
        off = tag[15:8] + 8'(4 * k);
        // R3 (R6: later words carry a wrong tag)
        chk(obs_off == off, k > 0 ? "R6" : "R3", 32'(obs_off), 32'(off));
      end else begin
        chk(obs_t == tag[7:6], "R4", 32'(obs_t), 32'(tag[7:6]));
        chk(obs_l == (tag[5] & eob), "R5", 32'(obs_l), 32'(tag[5] & eob));
      end
    end
  endtask

  task automatic send_block(input logic [15:0] tag, input int len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      s_valid = 1;
      s_data  = {tag, 8'(k), 8'h5A};
      s_tag   = (k == 0) ? tag : ~tag;
      s_eob   = (k == len - 1);
      #1;
      check_word(tag, k, k == len - 1, 1'b1);
    end
    @(posedge clk);
    if (port_of(tag[3:0]) == 3) exp_err = 1;
    @(negedge clk);
    s_valid = 0;
    s_eob = 0;
    #1;
    // R8 sticky flag
    chk(drop_err == exp_err, "R8", 32'(drop_err), 32'(exp_err));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R9
    chk(drop_err == 1'b0, "R9", 32'(drop_err), 0);
    chk({a_we, h_we, b_we, a_dv, h_dv, b_dv} == 6'd0, "R9",
        32'({a_we, h_we, b_we, a_dv, h_dv, b_dv}), 0);

    // Sweep of legal codes first (flag must stay clear), then all codes
    for (int pass = 0; pass < 2; pass++)
      for (int e = 0; e < 16; e++) begin
        if (pass == 0 && port_of(4'(e)) == 3) continue;
        for (int c = 0; c < 2; c++)
          for (int l = 0; l < 2; l++)
            for (int n = 1; n <= 3; n++) begin
              logic [15:0] t;
              t = {4'(e), 4'h8, 2'(e + n), 1'(l), 1'(c), 4'(e)};
              send_block(t, n);
            end
      end

    // R7 back-pressure on the hash data port
    @(negedge clk);
    h_rdy = 0;
    s_valid = 1; s_tag = 16'h00A3; s_data = 32'hCAFE0001; s_eob = 1;
    for (int i = 0; i < 3; i++) begin
      #1;
      check_word(16'h00A3, 0, 1'b1, 1'b0);
      @(negedge clk);
    end
    h_rdy = 1;
    #1;
    check_word(16'h00A3, 0, 1'b1, 1'b1);
    @(negedge clk);
    s_valid = 0; s_eob = 0;
    // a stalled word must not have advanced the block: new block sees its own tag
    send_block(16'h2011, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule